// File: doc/BRIEF.md
# Byte-Wide Framed Packet Transmitter

This block pulls packet bytes from a show-ahead transmit FIFO and places them on an 8-bit output bus with two control lines, `tx_en` and `tx_er`. Each FIFO entry carries one byte plus a start marker, an end marker and an error marker. A pop happens in the same cycle that `fifo_rd` is high. Every output is registered, so a byte popped in cycle t appears on the bus after the clock edge that ends cycle t.

There are two framing modes, selected by `mode_enc`. In enable-framed mode (`mode_enc`=0), `tx_en` is high for the whole packet and the packet is never paused. If the FIFO runs dry in this mode, the packet is cut off with an error beat and an underrun pulse. In encoded mode (`mode_enc`=1), the pair {`tx_en`,`tx_er`} gives every beat a state. Not-valid beats may appear anywhere inside a packet. They cover both pause requests and FIFO starvation, and neither of these raises an error. The mode is captured when a packet starts and holds until that packet ends.

Top module: `pkt_byte_tx`

## Requirements
- R1: While `rst_n` is low, `tx_en`, `tx_er`, `underrun`, `fifo_rd` and `tx_data` are all 0.
- R2: In encoded mode the beat code {`tx_en`,`tx_er`} is 11 for a start beat, 10 for a middle beat, 01 for an end beat and 00 for not valid. A not-valid beat drives `tx_data` to 0.
- R3: A FIFO entry with both the start and end markers set is one complete packet. In encoded mode it goes out as a single 01 beat. In enable-framed mode it goes out as a single beat with `tx_en`=1.
- R4: In encoded mode, an empty FIFO during a packet produces 00 beats and never raises `underrun`. The packet then resumes where it stopped.
- R5: In encoded mode, each cycle with `pause` high during a packet produces one 00 beat, and nothing is popped.
- R6: In both modes, `pause` high while no packet is in progress keeps a waiting start entry from being sent.
- R7: In enable-framed mode, `tx_en` is 1 from the start byte through the end byte. It is 0 for at least one cycle before the next packet begins.
- R8: In enable-framed mode, `pause` has no effect once a packet has started. A byte goes out every cycle.
- R9: In enable-framed mode, an entry whose error marker is set is sent with `tx_er`=1. Other entries are sent with `tx_er`=0.
- R10: In enable-framed mode, an empty FIFO during a packet ends the packet with one beat of `tx_en`=1, `tx_er`=1 and `tx_data`=0. `underrun` is high for that one cycle only.
- R11: A change of `mode_enc` while a packet is in progress takes effect only after that packet ends.
- R12: `fifo_rd` is never high while `fifo_empty` is high. Between packets, an entry without the start marker is popped and discarded and produces no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_enc | input | 1 | 0 = enable-framed mode, 1 = encoded beat mode |
| pause | input | 1 | Flow-control hold request |
| fifo_empty | input | 1 | FIFO has no entry |
| fifo_data | input | 8 | Byte at the head of the FIFO |
| fifo_sop | input | 1 | Head entry starts a packet |
| fifo_eop | input | 1 | Head entry ends a packet |
| fifo_err | input | 1 | Head entry is marked bad (used in enable-framed mode) |
| fifo_rd | output | 1 | Pop the head entry this cycle |
| tx_data | output | 8 | Output byte |
| tx_en | output | 1 | Enable line, or the upper bit of the beat code |
| tx_er | output | 1 | Error line, or the lower bit of the beat code |
| underrun | output | 1 | One-cycle pulse when an enable-framed packet is cut off |

## Verification
The in-packet flag and the latched mode are the only state. A stale in-packet flag shows at the ports in the next beat: either a spurious error beat with an underrun pulse, or a start beat missing where one is due. A wrong latched mode shows in the next beat as the wrong code, or as a byte going out where a pause should have left a gap. Because every output is registered, each of these faults reaches the pins exactly one edge after the cycle that caused it. The stimulus walks pause and starvation through both modes, including a mode change inside a packet.

// File: rtl/pkt_byte_tx.sv
module pkt_byte_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_enc,
  input  logic          pause,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_sop,
  input  logic          fifo_eop,
  input  logic          fifo_err,
  output logic          fifo_rd,
  output logic [DW-1:0] tx_data,
  output logic          tx_en,
  output logic          tx_er,
  output logic          underrun
);

  logic busy;
  logic mode_q;

  logic start, drop, mid_pop, starve;

  assign start   = !busy && !fifo_empty && fifo_sop && !pause && (mode_enc || !tx_en);
  assign drop    = !busy && !fifo_empty && !fifo_sop;
  assign mid_pop = busy && !fifo_empty && (!mode_q || !pause);
  assign starve  = busy && !mode_q && fifo_empty;
  assign fifo_rd = rst_n && (start || drop || mid_pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      mode_q   <= 1'b0;
      tx_data  <= '0;
      tx_en    <= 1'b0;
      tx_er    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      tx_data  <= '0;
      tx_en    <= 1'b0;
      tx_er    <= 1'b0;
      underrun <= 1'b0;
      if (start) begin
        mode_q  <= mode_enc;
        busy    <= !fifo_eop;
        tx_data <= fifo_data;
        if (mode_enc) begin
          tx_en <= !fifo_eop;
          tx_er <= 1'b1;
        end else begin
          tx_en <= 1'b1;
          tx_er <= fifo_err;
        end
      end else if (mid_pop) begin
        tx_data <= fifo_data;
        if (fifo_eop) busy <= 1'b0;
        if (mode_q) begin
          tx_en <= !fifo_eop;
          tx_er <= fifo_eop;
        end else begin
          tx_en <= 1'b1;
          tx_er <= fifo_err;
        end
      end else if (starve) begin
        busy     <= 1'b0;
        tx_en    <= 1'b1;
        tx_er    <= 1'b1;
        underrun <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pkt_byte_tx_chk.sv
module pkt_byte_tx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mode_q,
  input logic          fifo_rd,
  input logic          fifo_empty,
  input logic [DW-1:0] tx_data,
  input logic          tx_en,
  input logic          tx_er,
  input logic          underrun
);

  always_comb begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (!tx_en && !tx_er && !underrun && !fifo_rd && tx_data == '0);
    end
  end

  assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_er) |-> tx_data == '0);

  assert_enc_no_underrun_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mode_q) |=> !underrun);

  assert_gmii_no_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mode_q) |=> tx_en);

  assert_underrun_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (tx_en && tx_er && tx_data == '0));

  assert_underrun_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

  assert_mode_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(mode_q));

  assert_no_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_rd && fifo_empty));

endmodule

bind pkt_byte_tx pkt_byte_tx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mode_q(mode_q),
  .fifo_rd(fifo_rd), .fifo_empty(fifo_empty), .tx_data(tx_data),
  .tx_en(tx_en), .tx_er(tx_er), .underrun(underrun)
);

// File: tb/sim_pkt_byte_tx.sv
module sim_pkt_byte_tx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_enc = 1'b1, pause = 1'b0, hold = 1'b0;
  logic fifo_empty, fifo_rd, fifo_sop, fifo_eop, fifo_err;
  logic [7:0] fifo_data, tx_data;
  logic tx_en, tx_er, underrun;

  int total = 0;
  int bad = 0;
  int empty_pops = 0;

  logic [10:0] mem [0:31];
  int wp = 0;
  int rp = 0;

  always #5 clk = ~clk;

  assign fifo_empty = hold || (rp == wp);
  assign {fifo_err, fifo_sop, fifo_eop, fifo_data} = mem[rp[4:0]];

  always @(posedge clk) begin
    if (fifo_rd) begin
      if (fifo_empty) empty_pops <= empty_pops + 1;
      else rp <= rp + 1;
    end
  end

  pkt_byte_tx u0 (
    .clk(clk), .rst_n(rst_n), .mode_enc(mode_enc), .pause(pause),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_sop(fifo_sop),
    .fifo_eop(fifo_eop), .fifo_err(fifo_err), .fifo_rd(fifo_rd),
    .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er), .underrun(underrun)
  );

  // {mode, pause, hold, exp_en, exp_er, exp_data, exp_underrun}
  localparam logic [13:0] VEC [10] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // R6 pause holds start
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 1'b0},  // R2 start code
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12, 1'b0},  // R2 middle code
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // R5 pause gap
    {1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // R5 pause gap
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},  // R4 starved gap
    {1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h13, 1'b0},  // R4 resumes
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h14, 1'b0},  // R2 end code
    {1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h15, 1'b0},  // R3 single entry
    {1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0}   // R2 idle code
  };

  task automatic push(input logic err, input logic sop, input logic eop, input logic [7:0] d);
    mem[wp[4:0]] = {err, sop, eop, d};
    wp = wp + 1;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic p, input logic h,
                      input logic en, input logic er, input logic [7:0] d,
                      input logic ur, input string tag);
    mode_enc = m; pause = p; hold = h;
    @(posedge clk);
    @(negedge clk);
    check(tag, "beat", {tx_en, tx_er, tx_data, underrun}, {en, er, d, ur});
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    push(0, 1, 0, 8'h11); push(0, 0, 0, 8'h12); push(0, 0, 0, 8'h13); push(0, 0, 1, 8'h14);
    push(0, 1, 1, 8'h15);
    push(0, 1, 0, 8'h21); push(1, 0, 0, 8'h22); push(0, 0, 0, 8'h23); push(0, 0, 1, 8'h24);
    push(0, 1, 1, 8'h31);
    push(0, 1, 0, 8'h41); push(0, 0, 0, 8'h42);
    push(0, 0, 0, 8'h43);
    push(0, 1, 1, 8'h51);

    repeat (3) @(negedge clk);
    check("R1", "reset outputs", {tx_en, tx_er, tx_data, underrun, fifo_rd}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < 10; i++) begin
      step(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9],
           VEC[i][8:1], VEC[i][0], "R2/R3/R4/R5/R6 table");
    end

    step(0, 1, 0, 0, 0, 8'h00, 0, "R6");
    step(0, 0, 0, 1, 0, 8'h21, 0, "R7");
    step(0, 1, 0, 1, 1, 8'h22, 0, "R9");
    step(0, 1, 0, 1, 0, 8'h23, 0, "R8");
    step(0, 0, 0, 1, 0, 8'h24, 0, "R7");
    step(0, 0, 0, 0, 0, 8'h00, 0, "R7");
    step(0, 0, 0, 1, 0, 8'h31, 0, "R3");
    step(0, 0, 0, 0, 0, 8'h00, 0, "R7");
    step(0, 0, 0, 1, 0, 8'h41, 0, "R7");
    step(1, 1, 0, 1, 0, 8'h42, 0, "R11");
    step(0, 0, 1, 1, 1, 8'h00, 1, "R10");
    step(0, 0, 0, 0, 0, 8'h00, 0, "R10");
    step(0, 0, 0, 1, 0, 8'h51, 0, "R12");
    step(0, 0, 0, 0, 0, 8'h00, 0, "R7");

    check("R12", "entries left", wp - rp, 0);
    check("R12", "pops while empty", empty_pops, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule